// File: doc/BRIEF.md
# Masked Interrupt Vector Encoder

This block collects level event inputs from up to 32 peripheral sources and folds them into one pending bit per source. A software-written mask register enables sources one by one. Among the sources that are both pending and enabled, the one with the lowest index wins. Its code is placed in a read-only vector word, and a single request line tells the core that service is needed.

Software can disable the very source that is requesting service on the same clock edge. If that write leaves no other enabled source pending, the block latches an error condition. That condition keeps the request line high and makes the vector word read as the error code. Software must provide a handler for this code. The condition cannot be masked, and only a read of the vector word removes it.

The register port is a plain one-cycle strobe interface with no back-pressure. A write takes effect on the clock edge that samples it. A read returns its data one clock after the strobe.

Top module: `irq_vector_encoder`

## Requirements
- R1: After reset the mask register reads 0, the vector word reads 0 and `irq_o` is low, whatever the event inputs are.
- R2: A write with `bus_sel`=0 loads the mask register from `bus_wdata`. Bit n of the mask enables source n, independent of that source's priority. A read with `bus_sel`=0 returns the mask on `bus_rdata` one clock after the strobe.
- R3: The pending bit of source n is the OR of event inputs `evt_i[2n]` and `evt_i[2n+1]`, registered once. It stays set until both of those inputs are low.
- R4: Among the sources that are pending and enabled, the lowest index has the highest priority. The vector code for source n is n+1.
- R5: A read with `bus_sel`=1 returns the vector code in bits 31:24 and zero in bits 23:0. A write with `bus_sel`=1 has no effect on either register.
- R6: The vector word is refreshed on every clock from the registered pending and mask bits. When no source is pending and enabled, it holds code 0.
- R7: `irq_o` is high while any source is pending and enabled, or while the error condition is latched.
- R8: A mask write that disables a source which is currently pending and enabled, and that leaves no pending source enabled, latches the error condition. While the error condition is latched and no source is active, the vector code is 0.
- R9: The error condition is unaffected by later mask writes. It clears on the clock edge of a vector read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 64 | Level event inputs, two per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 1 | 0 = mask register, 1 = vector word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read strobe |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
An event change reaches the pending register on the first edge after it is driven. It reaches `irq_o` just after that edge and the vector word on the second edge. A read strobe issued after that returns the word one edge later. Mask writes and the error latch act on `irq_o` right after the edge that samples the write.

The bench holds the event inputs steady for three clocks before it looks at the outputs. It samples every output on the falling edge, after all updates are due. A reference model in the bench tracks the mask and the error latch so that each expected value is ready when its result appears.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int WORD_W = 32;
  localparam int CODE_W = 8;

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_VEC  = 1'b1
  } bus_sel_e;
endpackage

// File: rtl/ivec_pend.sv
module ivec_pend #(
  parameter int NSRC = 32,
  parameter int EPS  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC*EPS-1:0] evt_i,
  output logic [NSRC-1:0]     pend_o
);
  logic [NSRC-1:0] pend_d;

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    assign pend_d[n] = |evt_i[n*EPS +: EPS];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= pend_d;
  end

  // Each pending bit follows its own event group one clock later.
  assert_pend_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[EPS-1:0] == '0) |=> !pend_o[0]);
endmodule

// File: rtl/ivec_mask.sv
module ivec_mask
  import ivec_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [NSRC-1:0]   wdata_i,
  input  logic [NSRC-1:0]   pend_i,
  output logic [NSRC-1:0]   mask_o,
  output logic              err_o,
  output logic              race_o
);
  logic [NSRC-1:0] drop_hit;
  logic [NSRC-1:0] keep_hit;

  assign drop_hit = pend_i & mask_o & ~wdata_i;
  assign keep_hit = pend_i & wdata_i;
  assign race_o   = wr_i && (|drop_hit) && !(|keep_hit);

  always_ff @(posedge clk) begin
    if (!rst_n)    mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       err_o <= 1'b0;
    else if (race_o)  err_o <= 1'b1;
    else if (clr_i)   err_o <= 1'b0;
  end

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_o == $past(wdata_i)));

  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_i) |=> err_o);
endmodule

// File: rtl/ivec_prio.sv
module ivec_prio
  import ivec_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   act_i,
  output logic [CODE_W-1:0] vec_o
);
  logic [CODE_W-1:0] win;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act_i[i]) win = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vec_o <= '0;
    else        vec_o <= win;
  end

  assert_top_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_i[0] |=> (vec_o == CODE_W'(1)));

  assert_idle_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == '0) |=> (vec_o == '0));
endmodule

// File: rtl/irq_vector_encoder.sv
module irq_vector_encoder
  import ivec_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int EPS  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC*EPS-1:0] evt_i,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic                bus_sel,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                irq_o
);
  localparam int PAD_W = WORD_W - CODE_W;

  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   mask;
  logic [NSRC-1:0]   act;
  logic [CODE_W-1:0] vec;
  logic              err;
  logic              race;
  logic              mask_wr;
  logic              vec_rd;

  assign mask_wr = bus_wr && (bus_sel == SEL_MASK);
  assign vec_rd  = bus_rd && (bus_sel == SEL_VEC);
  assign act     = pend & mask;
  assign irq_o   = (|act) || err;

  ivec_pend #(.NSRC(NSRC), .EPS(EPS)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .pend_o(pend)
  );

  ivec_mask #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(mask_wr), .clr_i(vec_rd),
    .wdata_i(bus_wdata[NSRC-1:0]), .pend_i(pend),
    .mask_o(mask), .err_o(err), .race_o(race)
  );

  ivec_prio #(.NSRC(NSRC)) u_prio (
    .clk(clk), .rst_n(rst_n), .act_i(act), .vec_o(vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      if (bus_sel == SEL_VEC) bus_rdata <= {vec, {PAD_W{1'b0}}};
      else                    bus_rdata <= WORD_W'(mask);
    end
  end

  assert_vec_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> (bus_rdata[PAD_W-1:0] == '0));

  assert_race_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    race |=> irq_o);

  assert_irq_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|act) |-> irq_o);
endmodule

// File: tb/irq_vector_encoder_test.sv
`timescale 1ns/1ps
module irq_vector_encoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt_i = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m_mask = '0;
  bit          m_err = 1'b0;

  always #4 clk = ~clk;

  irq_vector_encoder uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] pend_of(logic [63:0] e);
    logic [31:0] p;
    for (int n = 0; n < 32; n++) p[n] = e[2*n] | e[2*n+1];
    return p;
  endfunction

  function automatic logic [7:0] code_of(logic [31:0] a);
    for (int n = 0; n < 32; n++) if (a[n]) return 8'(n + 1);
    return 8'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_reg(logic sel, logic [31:0] d);
    logic [31:0] p;
    p = pend_of(evt_i);
    if (sel == 1'b0) begin
      if (((p & m_mask & ~d) != 0) && ((p & d) == 0)) m_err = 1'b1;
      m_mask = d;
    end
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(logic sel, output logic [31:0] v);
    bus_rd = 1'b1; bus_sel = sel;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
    if (sel == 1'b1) m_err = 1'b0;
  endtask

  task automatic check_vec(string req);
    logic [31:0] v;
    logic [31:0] a;
    a = pend_of(evt_i) & m_mask;
    rd_reg(1'b1, v);
    check(req, v, {code_of(a), 24'h0});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] a;
    void'($urandom(32'd1234));
    evt_i = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    rst_n = 1'b1;
    settle();
    check("R1 irq masked", {31'd0, irq_o}, 32'd0);
    rd_reg(1'b0, v); check("R1 mask", v, 32'd0);
    rd_reg(1'b1, v); check("R1 vec", v, 32'd0);

    // R2: mask readback, fixed bit positions
    wr_reg(1'b0, 32'hA5C3_0F18);
    rd_reg(1'b0, v); check("R2 mask readback", v, 32'hA5C3_0F18);
    // R5: write to vector word ignored
    wr_reg(1'b1, 32'hFFFF_FFFF);
    rd_reg(1'b0, v); check("R5 mask unchanged", v, 32'hA5C3_0F18);
    settle();
    check_vec("R5 vec unchanged");

    // R4: several pending, lowest enabled wins
    evt_i = '0;
    wr_reg(1'b0, 32'h0000_0000);
    evt_i[2*3] = 1'b1; evt_i[2*7+1] = 1'b1; evt_i[2*20] = 1'b1;
    wr_reg(1'b0, 32'h0010_0088);
    settle();
    check("R7 irq active", {31'd0, irq_o}, 32'd1);
    rd_reg(1'b1, v); check("R4 winner 3", v, {8'd4, 24'h0});
    // mask winner: next one wins, no error (R8 negative)
    wr_reg(1'b0, 32'h0010_0080);
    settle();
    rd_reg(1'b1, v); check("R4 winner 7", v, {8'd8, 24'h0});
    wr_reg(1'b0, 32'h0010_0000);
    settle();
    rd_reg(1'b1, v); check("R6 winner 20", v, {8'd21, 24'h0});

    // R8: race - disable the only active source
    evt_i = '0; evt_i[2*5] = 1'b1;
    wr_reg(1'b0, 32'h0000_0020);
    settle();
    check("R7 irq src5", {31'd0, irq_o}, 32'd1);
    wr_reg(1'b0, 32'h0000_0000);
    check("R8 irq held by error", {31'd0, irq_o}, 32'd1);
    settle();
    // R9: unmaskable by later mask writes
    wr_reg(1'b0, 32'h0000_0000);
    check("R9 irq after mask write", {31'd0, irq_o}, 32'd1);
    rd_reg(1'b1, v); check("R8 error code", v, 32'd0);
    check("R9 cleared by read", {31'd0, irq_o}, 32'd0);

    // R3: pending fed by two events, cleared one at a time
    evt_i = '0; evt_i[2*9] = 1'b1; evt_i[2*9+1] = 1'b1;
    wr_reg(1'b0, 32'h0000_0200);
    settle();
    check("R3 both set", {31'd0, irq_o}, 32'd1);
    evt_i[2*9] = 1'b0;
    settle();
    check("R3 one cleared", {31'd0, irq_o}, 32'd1);
    rd_reg(1'b1, v); check("R3 vec still 9", v, {8'd10, 24'h0});
    evt_i[2*9+1] = 1'b0;
    settle();
    check("R3 both cleared", {31'd0, irq_o}, 32'd0);
    rd_reg(1'b1, v); check("R6 idle code", v, 32'd0);

    // random phase
    for (int it = 0; it < 60; it++) begin
      evt_i = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      settle();
      a = pend_of(evt_i) & m_mask;
      check("R7 irq random", {31'd0, irq_o}, {31'd0, (a != 0) || m_err});
      wr_reg(1'b0, $urandom & $urandom);
      settle();
      a = pend_of(evt_i) & m_mask;
      check("R8 irq after write", {31'd0, irq_o}, {31'd0, (a != 0) || m_err});
      check_vec("R4 random vec");
      check("R9 irq after read", {31'd0, irq_o}, {31'd0, a != 0});
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule